// File: doc/BRIEF.md
# Block-Transfer Sequencer

This block accepts a single multi-register transfer command and expands it into a series of single-word memory accesses. A command carries a 16-bit register-select mask, a 32-bit base address, a direction flag (load or store), a 2-bit addressing mode, a writeback flag and a status-restore modifier. The block walks the mask from register 0 up to register 15, whatever order the programmer wrote the list in. For each selected register it drives the register index, the word address and a read or write strobe, and it holds them until memory signals ready.

After the last access the block pulses `done` for one cycle. With that pulse it presents the final base value, a flag that says whether the base should be written back, and a flag for the status-restore case. Stack mnemonics are resolved before the command arrives: push means store/DB/writeback, pop means load/IA/writeback, a full-descending load is IA and a full-descending store is DB. For an empty-descending stack, the store uses DA and the matching load uses IB.

The state machine has three states:
- IDLE: waits for `cmd_valid`.
- XFER: one access is in flight.
- DONE: `done` is asserted for one cycle.

It has four transitions:
- IDLE→XFER: a command with a non-zero mask is accepted.
- IDLE→DONE: a command with an all-zero mask is accepted.
- XFER→XFER: the access is accepted and more registers remain.
- XFER→DONE: the last access is accepted.

After DONE the block always returns to IDLE.

Top module: `ldm_seq_top`

## Requirements
- R1: After reset the block is in IDLE. `cmd_ready` is 1, and `mem_req`, `done`, `wb_en` and `psr_restore` are all 0.
- R2: A command is accepted only when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only in IDLE. A `cmd_valid` that arrives while a sequence is running has no effect on that sequence.
- R3: Selected registers are transferred in ascending index order, one access per set bit of the mask. `mem_reg` holds the register index.
- R4: Consecutive accesses step the address by 4. The lowest-numbered register always uses the lowest address.
- R5: The first address depends on the mode. Mode 0 (IA) starts at B. Mode 1 (IB) starts at B+4. Mode 2 (DA) starts at B−4N+4. Mode 3 (DB) starts at B−4N. N is the number of set bits in the mask.
- R6: `mem_addr`, `mem_reg`, `mem_we` and `mem_req` stay stable until `mem_ready` is sampled high while `mem_req` is 1.
- R7: `mem_we` is 1 for a store (`cmd_load`=0) and 0 for a load (`cmd_load`=1).
- R8: `done` is a one-cycle pulse. It comes one cycle after the last accepted access. `final_base` is B+4N for modes 0 and 1, and B−4N for modes 2 and 3.
- R9: With the `done` pulse, `wb_en` equals the command's writeback flag.
- R10: With the `done` pulse, `psr_restore` is 1 only if the command was a load, the restore modifier was set and mask bit 15 was set.
- R11: An all-zero mask makes no memory access. `done` comes one cycle after acceptance, with `final_base` equal to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and can accept a command |
| cmd_mask | input | 16 | Register-select mask |
| cmd_base | input | 32 | Base address |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_mode | input | 2 | 0 = IA, 1 = IB, 2 = DA, 3 = DB |
| cmd_wb | input | 1 | Write back the updated base |
| cmd_restore | input | 1 | Status-restore modifier |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address |
| mem_reg | output | 4 | Register index of the current access |
| mem_ready | input | 1 | Memory accepts the access |
| done | output | 1 | Sequence complete (one-cycle pulse) |
| final_base | output | 32 | Updated base value |
| wb_en | output | 1 | Base should be written back |
| psr_restore | output | 1 | Status should be restored |

## Verification
The hardest behaviour to reach from the ports is an access held under back-pressure while a new command is offered at the same time. In that situation the outputs must stay frozen, and the new command must not disturb the running sequence. The bench gets there with a memory responder that holds `mem_ready` low for several cycles on chosen accesses. During those stalled cycles the bench also keeps `cmd_valid` high with a different command. Scattered masks, masks with a single bit, the full mask and the empty mask cover the edges of the bit scan and of the address arithmetic.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;
    typedef enum logic [1:0] {
        MODE_IA = 2'd0,
        MODE_IB = 2'd1,
        MODE_DA = 2'd2,
        MODE_DB = 2'd3
    } addr_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ldm_popcount.sv
module ldm_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ldm_lowest_bit.sv
module ldm_lowest_bit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ldm_addr_calc.sv
module ldm_addr_calc
    import ldm_seq_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  addr_mode_t    mode,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_base
);
    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count) * AW'(STEP);
        unique case (mode)
            MODE_IA: begin
                start_addr = base;
                end_base   = base + span;
            end
            MODE_IB: begin
                start_addr = base + AW'(STEP);
                end_base   = base + span;
            end
            MODE_DA: begin
                start_addr = base - span + AW'(STEP);
                end_base   = base - span;
            end
            MODE_DB: begin
                start_addr = base - span;
                end_base   = base - span;
            end
        endcase
    end
endmodule

// File: rtl/ldm_seq_top.sv
module ldm_seq_top
    import ldm_seq_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int STEP = 4,
    localparam int RW  = $clog2(NREG),
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [NREG-1:0] cmd_mask,
    input  logic [AW-1:0]   cmd_base,
    input  logic            cmd_load,
    input  logic [1:0]      cmd_mode,
    input  logic            cmd_wb,
    input  logic            cmd_restore,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [RW-1:0]   mem_reg,
    input  logic            mem_ready,
    output logic            done,
    output logic [AW-1:0]   final_base,
    output logic            wb_en,
    output logic            psr_restore
);
    seq_state_t    state_q, state_d;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] fbase_q;
    logic          load_q, wb_q, rst_q;

    logic [CW-1:0] cmd_cnt;
    logic [AW-1:0] cmd_start, cmd_end;
    logic [RW-1:0] cur_idx;
    logic          cur_any;
    logic [NREG-1:0] pend_next;
    logic          accept, beat;

    ldm_popcount #(.W(NREG), .CW(CW)) u_cnt (
        .vec(cmd_mask),
        .cnt(cmd_cnt)
    );

    ldm_addr_calc #(.AW(AW), .CW(CW), .STEP(STEP)) u_addr (
        .base      (cmd_base),
        .count     (cmd_cnt),
        .mode      (addr_mode_t'(cmd_mode)),
        .start_addr(cmd_start),
        .end_base  (cmd_end)
    );

    ldm_lowest_bit #(.W(NREG), .IW(RW)) u_pick (
        .vec(pend_q),
        .idx(cur_idx),
        .any(cur_any)
    );

    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign beat      = (state_q == ST_XFER) && mem_ready;
    assign pend_next = pend_q & (pend_q - NREG'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = (cmd_mask == '0) ? ST_DONE : ST_XFER;
            ST_XFER: if (mem_ready && pend_next == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            addr_q  <= '0;
            fbase_q <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            rst_q   <= 1'b0;
        end else if (accept) begin
            pend_q  <= cmd_mask;
            addr_q  <= cmd_start;
            fbase_q <= cmd_end;
            load_q  <= cmd_load;
            wb_q    <= cmd_wb;
            rst_q   <= cmd_load && cmd_restore && cmd_mask[NREG-1];
        end else if (beat) begin
            pend_q  <= pend_next;
            addr_q  <= addr_q + AW'(STEP);
        end
    end

    // outputs
    always_comb begin
        cmd_ready   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_reg     = '0;
        done        = 1'b0;
        final_base  = '0;
        wb_en       = 1'b0;
        psr_restore = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_XFER: begin
                mem_req  = 1'b1;
                mem_we   = !load_q;
                mem_addr = addr_q;
                mem_reg  = cur_idx;
            end
            ST_DONE: begin
                done        = 1'b1;
                final_base  = fbase_q;
                wb_en       = wb_q;
                psr_restore = rst_q;
            end
            default: ;
        endcase
    end

    AST_XFER_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> cur_any); // R3
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_we))); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(STEP))); // R4
    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_reg > $past(mem_reg))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && (mem_req || done))); // R2
    AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en || psr_restore) |-> done); // R9
endmodule

// File: tb/tb_ldm_seq_top.sv
module tb_ldm_seq_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [15:0] cmd_mask = 0;
    logic [31:0] cmd_base = 0;
    logic        cmd_load = 0;
    logic [1:0]  cmd_mode = 0;
    logic        cmd_wb = 0;
    logic        cmd_restore = 0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_reg;
    logic        mem_ready = 0;
    logic        done;
    logic [31:0] final_base;
    logic        wb_en, psr_restore;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ldm_seq_top dut (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one command. stall gives the extra wait cycles before each beat.
    // noise keeps cmd_valid high with another command while the sequence runs.
    task automatic run_cmd(input logic [15:0] m, input logic [31:0] b, input logic ld,
                           input logic [1:0] md, input logic wb, input logic rs,
                           input int stall, input bit noise);
        int n = $countones(m);
        logic [31:0] start, fin;
        int k = 0;
        int waitc;
        case (md)
            2'd0: begin start = b;             fin = b + 32'(4*n); end
            2'd1: begin start = b + 4;         fin = b + 32'(4*n); end
            2'd2: begin start = b - 32'(4*n) + 4; fin = b - 32'(4*n); end
            default: begin start = b - 32'(4*n); fin = b - 32'(4*n); end
        endcase
        @(negedge clk);
        chk("R2", "ready before cmd", cmd_ready, 1);
        cmd_valid = 1; cmd_mask = m; cmd_base = b; cmd_load = ld;
        cmd_mode = md; cmd_wb = wb; cmd_restore = rs;
        @(negedge clk);
        if (noise) begin
            cmd_mask = ~m; cmd_base = b ^ 32'hFFF0; cmd_load = ~ld; cmd_mode = ~md; cmd_wb = ~wb;
        end else cmd_valid = 0;
        for (int r = 0; r < 16; r++) begin
            if (!m[r]) continue;
            chk("R6", "mem_req", mem_req, 1);
            chk("R3", "reg index", mem_reg, r);
            chk("R4", "addr", mem_addr, start + 32'(4*k));
            if (k == 0) chk("R5", "first addr", mem_addr, start);
            chk("R7", "we", mem_we, !ld);
            chk("R2", "ready low busy", cmd_ready, 0);
            for (waitc = 0; waitc < stall; waitc++) begin
                @(negedge clk);
                chk("R6", "held addr", mem_addr, start + 32'(4*k));
                chk("R6", "held reg", mem_reg, r);
            end
            mem_ready = 1;
            @(negedge clk);
            mem_ready = 0;
            k++;
        end
        chk("R11", "no req at end", mem_req, 0);
        chk("R8", "done", done, 1);
        chk("R8", "final base", final_base, fin);
        chk("R9", "wb_en", wb_en, wb);
        chk("R10", "psr", psr_restore, ld && rs && m[15]);
        cmd_valid = 0;
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ready", cmd_ready, 1);
        chk("R1", "req", mem_req, 0);
        chk("R1", "done", done, 0);
        chk("R1", "wb/psr", {wb_en, psr_restore}, 0);
        rst_n = 1;
        // IA load of r0..r3 at 0x1000, no writeback
        run_cmd(16'h000F, 32'h1000, 1, 2'd0, 0, 0, 0, 0);
        // scattered list {r5,r3,r0-r2,r14}, IB store with wb
        run_cmd(16'h402F, 32'h2000, 0, 2'd1, 1, 0, 1, 0);
        // DA load with restore but no r15
        run_cmd(16'h0110, 32'h3000, 1, 2'd2, 1, 1, 0, 0);
        // push: DB store with wb, stalls and a competing command
        run_cmd(16'h8007, 32'h4000, 0, 2'd3, 1, 1, 3, 1);
        // pop with status restore: load IA wb including r15
        run_cmd(16'h8007, 32'h3FF0, 1, 2'd0, 1, 1, 2, 0);
        // full mask, DB
        run_cmd(16'hFFFF, 32'h10000, 0, 2'd3, 0, 0, 0, 0);
        // single bit r15, DA
        run_cmd(16'h8000, 32'h500, 0, 2'd2, 1, 0, 1, 1);
        // empty mask: done one cycle after acceptance, base unchanged
        run_cmd(16'h0000, 32'hABC0, 1, 2'd3, 1, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule